// File: doc/BRIEF.md
# Indirect I/O Register Access Window

This block turns a small 32-byte I/O window into a path to a much larger internal address space. Software first loads a location into a pointer register. It then reads or writes a second, data register. Each data access is forwarded to the location the pointer holds, and the block decides by address range which back-side port carries it.

One back-side port serves internal registers and memories and takes a word address. The other serves a flash controller and takes a byte offset from the start of the flash range. Pointer values that fall between the two ranges are accepted on the host side but go nowhere. The host side is a plain slave with one-cycle read and write strobes and a ready output. The block holds that ready output low while a back-side access is in flight.

Byte enables decide which writes take effect. The pointer only changes on a full 32-bit write. Data writes into the internal range also need all four byte enables. Flash writes pass the host byte enables through unchanged.

Top module: `iowin_top`

## Requirements
- R1: Only byte offset 0x00 (pointer) and byte offset 0x04 (data) of the window are decoded. Any other offset, including 0x01, reads as 0x00000000 and ignores writes.
- R2: A pointer write changes the pointer only when the byte enables are 4'b1111. Any other byte-enable pattern leaves the pointer unchanged.
- R3: The pointer holds bits 19:0 only. Pointer bits 31:20 read back as zero whatever was written.
- R4: Either reset input (`rst_pwr` or `rst_bus`, synchronous, active high) clears the pointer to zero. Without a reset, the pointer keeps its value until the next accepted write.
- R5: A read of the pointer or the data register returns the full 32-bit word, whatever byte enables are presented.
- R6: Pointer values 0x00000 to 0x1FFFF select the internal port, with `int_addr` = pointer bits 16:2. Pointer bits 1:0 are ignored. A data write there issues an internal write only with byte enables 4'b1111; otherwise no internal request is made.
- R7: Pointer values 0x80000 to 0xFFFFF select the flash port, with `fl_addr` = pointer minus 0x80000. A flash write forwards the host byte enables and write data unchanged.
- R8: Pointer values 0x20000 to 0x7FFFF are undefined. A data write there is dropped, a data read returns 0x00000000, and neither back-side port raises a request.
- R9: A forwarded data access drops `h_ready` from the cycle after the strobe until the edge at which the selected port's ready is sampled high. Read data from that port is then latched onto `h_rdata`.
- R10: At most one back-side request is active at a time. A request and its address stay stable until its ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pwr | input | 1 | Power-good reset, synchronous, active high |
| rst_bus | input | 1 | Bus reset, synchronous, active high |
| h_addr | input | 5 | Byte offset within the I/O window |
| h_be | input | 4 | Host byte enables |
| h_wdata | input | 32 | Host write data |
| h_rd | input | 1 | Host read strobe, one cycle |
| h_wr | input | 1 | Host write strobe, one cycle |
| h_rdata | output | 32 | Read data of the last completed read |
| h_ready | output | 1 | High when idle and able to take a strobe |
| int_req | output | 1 | Internal-port request |
| int_we | output | 1 | Internal-port write enable |
| int_addr | output | 15 | Internal-port word address |
| int_be | output | 4 | Internal-port byte enables |
| int_wdata | output | 32 | Internal-port write data |
| int_rdata | input | 32 | Internal-port read data |
| int_ready | input | 1 | Internal-port completion |
| fl_req | output | 1 | Flash-port request |
| fl_we | output | 1 | Flash-port write enable |
| fl_addr | output | 19 | Flash byte offset |
| fl_be | output | 4 | Flash-port byte enables |
| fl_wdata | output | 32 | Flash-port write data |
| fl_rdata | input | 32 | Flash-port read data |
| fl_ready | input | 1 | Flash-port completion |

## Verification
The properties assume the host raises a strobe only while `h_ready` is high, never raises both strobes together, and that a back-side ready appears only while that port's request is up. The bench's driver tasks respect all three. Each task waits for `h_ready` before it raises a single strobe for exactly one cycle. The back-side responder models raise ready only on a pending request, after a latency the bench sets. Strobes that arrive while the block is busy are therefore never produced, and their handling is left unchecked.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
    localparam int HOST_DW = 32;
    localparam int HOST_AW = 5;
    localparam int BE_W    = 4;
    localparam int AREG_W  = 20;

    localparam logic [AREG_W-1:0] INT_LAST   = 20'h1FFFF;
    localparam logic [AREG_W-1:0] FLASH_BASE = 20'h80000;

    // internal word address width, flash offset width
    localparam int INT_WA_W = $clog2(int'(INT_LAST) + 1) - 2;
    localparam int FL_AW    = $clog2((1 << AREG_W) - int'(FLASH_BASE));

    localparam logic [HOST_AW-1:0] OFS_PTR  = 5'h00;
    localparam logic [HOST_AW-1:0] OFS_DATA = 5'h04;

    typedef enum logic [1:0] {SEL_PTR, SEL_DATA, SEL_NONE} sel_e;
    typedef enum logic [1:0] {RGN_INT, RGN_UNDEF, RGN_FLASH} rgn_e;
    typedef enum logic [1:0] {ST_IDLE, ST_INT, ST_FL} st_e;

    typedef struct packed {
        logic               we;
        logic [BE_W-1:0]    be;
        logic [HOST_DW-1:0] wdata;
    } bk_cmd_t;

    function automatic sel_e sel_of(input logic [HOST_AW-1:0] ofs);
        if (ofs == OFS_PTR)       return SEL_PTR;
        else if (ofs == OFS_DATA) return SEL_DATA;
        else                      return SEL_NONE;
    endfunction

    function automatic rgn_e rgn_of(input logic [AREG_W-1:0] a);
        if (a <= INT_LAST)         return RGN_INT;
        else if (a >= FLASH_BASE)  return RGN_FLASH;
        else                       return RGN_UNDEF;
    endfunction

    function automatic logic full_word(input logic [BE_W-1:0] be);
        return &be;
    endfunction
endpackage

// File: rtl/iowin_ptr_reg.sv
module iowin_ptr_reg
    import iowin_pkg::*;
#(
    parameter int AW = AREG_W,
    parameter int BW = BE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [BW-1:0] be,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] q
);
    // Narrow writes never reach the pointer.
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr && (&be))
            q <= wdata;
    end
endmodule

// File: rtl/iowin_decode.sv
module iowin_decode
    import iowin_pkg::*;
#(
    parameter int AW  = AREG_W,
    parameter int OW  = HOST_AW,
    parameter int IWW = INT_WA_W,
    parameter int FAW = FL_AW
) (
    input  logic [OW-1:0]  ofs,
    input  logic [AW-1:0]  ptr,
    output sel_e           sel,
    output rgn_e           rgn,
    output logic [IWW-1:0] int_wa,
    output logic [FAW-1:0] fl_off
);
    always_comb begin
        sel    = sel_of(ofs);
        rgn    = rgn_of(ptr);
        // word address drops the two byte bits
        int_wa = ptr[IWW+1:2];
        // flash base is aligned to its own size, so subtracting it clears the top bit
        fl_off = ptr[FAW-1:0];
    end
endmodule

// File: rtl/iowin_ctrl.sv
module iowin_ctrl
    import iowin_pkg::*;
#(
    parameter int DW  = HOST_DW,
    parameter int AW  = AREG_W,
    parameter int BW  = BE_W,
    parameter int IWW = INT_WA_W,
    parameter int FAW = FL_AW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rd_go,
    input  logic           wr_go,
    input  sel_e           sel,
    input  rgn_e           rgn,
    input  logic [BW-1:0]  be,
    input  logic [DW-1:0]  wdata,
    input  logic [AW-1:0]  ptr,
    input  logic [IWW-1:0] int_wa,
    input  logic [FAW-1:0] fl_off,
    input  logic           int_ready,
    input  logic [DW-1:0]  int_rdata,
    input  logic           fl_ready,
    input  logic [DW-1:0]  fl_rdata,
    output logic           busy,
    output logic [DW-1:0]  rdata,
    output logic           int_req,
    output logic [IWW-1:0] int_addr,
    output bk_cmd_t        int_cmd,
    output logic           fl_req,
    output logic [FAW-1:0] fl_addr,
    output bk_cmd_t        fl_cmd
);
    st_e st;

    assign busy = (st != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            rdata    <= '0;
            int_req  <= 1'b0;
            int_addr <= '0;
            int_cmd  <= '0;
            fl_req   <= 1'b0;
            fl_addr  <= '0;
            fl_cmd   <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (rd_go || wr_go) begin
                        unique case (sel)
                            SEL_PTR: begin
                                if (rd_go)
                                    rdata <= {{(DW-AW){1'b0}}, ptr};
                            end
                            SEL_DATA: begin
                                unique case (rgn)
                                    RGN_INT: begin
                                        if (rd_go || full_word(be)) begin
                                            int_req        <= 1'b1;
                                            int_addr       <= int_wa;
                                            int_cmd.we     <= wr_go;
                                            int_cmd.be     <= '1;
                                            int_cmd.wdata  <= wdata;
                                            st             <= ST_INT;
                                        end
                                    end
                                    RGN_FLASH: begin
                                        fl_req        <= 1'b1;
                                        fl_addr       <= fl_off;
                                        fl_cmd.we     <= wr_go;
                                        fl_cmd.be     <= wr_go ? be : '1;
                                        fl_cmd.wdata  <= wdata;
                                        st            <= ST_FL;
                                    end
                                    default: begin
                                        if (rd_go)
                                            rdata <= '0;
                                    end
                                endcase
                            end
                            default: begin
                                if (rd_go)
                                    rdata <= '0;
                            end
                        endcase
                    end
                end
                ST_INT: begin
                    if (int_ready) begin
                        int_req <= 1'b0;
                        if (!int_cmd.we)
                            rdata <= int_rdata;
                        st <= ST_IDLE;
                    end
                end
                ST_FL: begin
                    if (fl_ready) begin
                        fl_req <= 1'b0;
                        if (!fl_cmd.we)
                            rdata <= fl_rdata;
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/iowin_top.sv
module iowin_top
    import iowin_pkg::*;
#(
    parameter int DW  = HOST_DW,
    parameter int OW  = HOST_AW,
    parameter int BW  = BE_W,
    parameter int AW  = AREG_W,
    parameter int IWW = INT_WA_W,
    parameter int FAW = FL_AW
) (
    input  logic           clk,
    input  logic           rst_pwr,
    input  logic           rst_bus,
    input  logic [OW-1:0]  h_addr,
    input  logic [BW-1:0]  h_be,
    input  logic [DW-1:0]  h_wdata,
    input  logic           h_rd,
    input  logic           h_wr,
    output logic [DW-1:0]  h_rdata,
    output logic           h_ready,
    output logic           int_req,
    output logic           int_we,
    output logic [IWW-1:0] int_addr,
    output logic [BW-1:0]  int_be,
    output logic [DW-1:0]  int_wdata,
    input  logic [DW-1:0]  int_rdata,
    input  logic           int_ready,
    output logic           fl_req,
    output logic           fl_we,
    output logic [FAW-1:0] fl_addr,
    output logic [BW-1:0]  fl_be,
    output logic [DW-1:0]  fl_wdata,
    input  logic [DW-1:0]  fl_rdata,
    input  logic           fl_ready
);
    logic           rst;
    logic           busy;
    logic           rd_go;
    logic           wr_go;
    logic           ptr_wr;
    logic [AW-1:0]  areg_q;
    sel_e           sel;
    rgn_e           rgn;
    logic [IWW-1:0] int_wa;
    logic [FAW-1:0] fl_off;
    bk_cmd_t        int_cmd;
    bk_cmd_t        fl_cmd;

    assign rst     = rst_pwr | rst_bus;
    assign h_ready = ~busy;
    assign rd_go   = h_rd & ~busy;
    assign wr_go   = h_wr & ~busy;
    assign ptr_wr  = wr_go && (sel == SEL_PTR);

    iowin_decode #(.AW(AW), .OW(OW), .IWW(IWW), .FAW(FAW)) u_dec (
        .ofs    (h_addr),
        .ptr    (areg_q),
        .sel    (sel),
        .rgn    (rgn),
        .int_wa (int_wa),
        .fl_off (fl_off)
    );

    iowin_ptr_reg #(.AW(AW), .BW(BW)) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .wr    (ptr_wr),
        .be    (h_be),
        .wdata (h_wdata[AW-1:0]),
        .q     (areg_q)
    );

    iowin_ctrl #(.DW(DW), .AW(AW), .BW(BW), .IWW(IWW), .FAW(FAW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .rd_go     (rd_go),
        .wr_go     (wr_go),
        .sel       (sel),
        .rgn       (rgn),
        .be        (h_be),
        .wdata     (h_wdata),
        .ptr       (areg_q),
        .int_wa    (int_wa),
        .fl_off    (fl_off),
        .int_ready (int_ready),
        .int_rdata (int_rdata),
        .fl_ready  (fl_ready),
        .fl_rdata  (fl_rdata),
        .busy      (busy),
        .rdata     (h_rdata),
        .int_req   (int_req),
        .int_addr  (int_addr),
        .int_cmd   (int_cmd),
        .fl_req    (fl_req),
        .fl_addr   (fl_addr),
        .fl_cmd    (fl_cmd)
    );

    assign int_we    = int_cmd.we;
    assign int_be    = int_cmd.be;
    assign int_wdata = int_cmd.wdata;
    assign fl_we     = fl_cmd.we;
    assign fl_be     = fl_cmd.be;
    assign fl_wdata  = fl_cmd.wdata;
endmodule

// File: rtl/iowin_chk.sv
module iowin_chk
    import iowin_pkg::*;
(
    input logic                clk,
    input logic                rst_pwr,
    input logic                rst_bus,
    input logic [HOST_AW-1:0]  h_addr,
    input logic [BE_W-1:0]     h_be,
    input logic                h_rd,
    input logic                h_wr,
    input logic                h_ready,
    input logic [HOST_DW-1:0]  h_rdata,
    input logic                int_req,
    input logic                int_we,
    input logic [BE_W-1:0]     int_be,
    input logic [INT_WA_W-1:0] int_addr,
    input logic                int_ready,
    input logic                fl_req,
    input logic                fl_we,
    input logic [BE_W-1:0]     fl_be,
    input logic [FL_AW-1:0]    fl_addr,
    input logic                fl_ready,
    input logic [AREG_W-1:0]   areg_q
);
    logic rst;
    assign rst = rst_pwr | rst_bus;

    AST_OTHER_OFS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (h_ready && h_rd && h_addr != OFS_PTR && h_addr != OFS_DATA) |=> (h_rdata == '0)); // R1

    AST_PTR_NARROW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (h_ready && h_wr && h_addr == OFS_PTR && h_be != 4'hF) |=> $stable(areg_q)); // R2

    AST_PTR_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
        (h_ready && h_rd && h_addr == OFS_PTR) |=> (h_rdata[HOST_DW-1:AREG_W] == '0)); // R3

    AST_RESET_CLEARS: assert property (@(posedge clk)
        (rst_pwr || rst_bus) |=> (areg_q == '0)); // R4

    AST_INT_FULL_WRITE: assert property (@(posedge clk) disable iff (rst)
        (int_req && int_we) |-> (int_be == 4'hF)); // R6

    AST_FL_OFFSET: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_req) |-> (fl_addr == areg_q[FL_AW-1:0] && areg_q[AREG_W-1])); // R7

    AST_FL_BE_PASS: assert property (@(posedge clk) disable iff (rst)
        (h_ready && h_wr && h_addr == OFS_DATA && areg_q >= FLASH_BASE)
        |=> (fl_req && fl_we && fl_be == $past(h_be))); // R7

    AST_UNDEF_SILENT: assert property (@(posedge clk) disable iff (rst)
        (h_ready && (h_rd || h_wr) && h_addr == OFS_DATA
         && areg_q > INT_LAST && areg_q < FLASH_BASE) |=> (!int_req && !fl_req)); // R8

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (int_req || fl_req) |-> !h_ready); // R9

    AST_ONE_PORT: assert property (@(posedge clk) disable iff (rst)
        !(int_req && fl_req)); // R10

    AST_INT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (int_req && !int_ready) |=> (int_req && $stable(int_addr))); // R10

    AST_FL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fl_req && !fl_ready) |=> (fl_req && $stable(fl_addr))); // R10
endmodule

bind iowin_top iowin_chk u_chk (
    .clk       (clk),
    .rst_pwr   (rst_pwr),
    .rst_bus   (rst_bus),
    .h_addr    (h_addr),
    .h_be      (h_be),
    .h_rd      (h_rd),
    .h_wr      (h_wr),
    .h_ready   (h_ready),
    .h_rdata   (h_rdata),
    .int_req   (int_req),
    .int_we    (int_we),
    .int_be    (int_be),
    .int_addr  (int_addr),
    .int_ready (int_ready),
    .fl_req    (fl_req),
    .fl_we     (fl_we),
    .fl_be     (fl_be),
    .fl_addr   (fl_addr),
    .fl_ready  (fl_ready),
    .areg_q    (areg_q)
);

// File: tb/iowin_top_tb.sv
module iowin_top_tb;
    logic        clk = 1'b0;
    logic        rst_pwr = 1'b1;
    logic        rst_bus = 1'b1;
    logic [4:0]  h_addr = '0;
    logic [3:0]  h_be = '0;
    logic [31:0] h_wdata = '0;
    logic        h_rd = 1'b0;
    logic        h_wr = 1'b0;
    logic [31:0] h_rdata;
    logic        h_ready;
    logic        int_req, int_we;
    logic [14:0] int_addr;
    logic [3:0]  int_be;
    logic [31:0] int_wdata;
    logic [31:0] int_rdata = '0;
    logic        int_ready = 1'b0;
    logic        fl_req, fl_we;
    logic [18:0] fl_addr;
    logic [3:0]  fl_be;
    logic [31:0] fl_wdata;
    logic [31:0] fl_rdata = '0;
    logic        fl_ready = 1'b0;

    always #10 clk = ~clk;

    iowin_top u_dut (
        .clk(clk), .rst_pwr(rst_pwr), .rst_bus(rst_bus),
        .h_addr(h_addr), .h_be(h_be), .h_wdata(h_wdata), .h_rd(h_rd), .h_wr(h_wr),
        .h_rdata(h_rdata), .h_ready(h_ready),
        .int_req(int_req), .int_we(int_we), .int_addr(int_addr), .int_be(int_be),
        .int_wdata(int_wdata), .int_rdata(int_rdata), .int_ready(int_ready),
        .fl_req(fl_req), .fl_we(fl_we), .fl_addr(fl_addr), .fl_be(fl_be),
        .fl_wdata(fl_wdata), .fl_rdata(fl_rdata), .fl_ready(fl_ready)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // back-side models
    logic [31:0] imem [0:255];
    int          int_lat = 1;
    int          fl_lat  = 1;
    int          int_txn = 0;
    int          int_wr_txn = 0;
    int          fl_txn = 0;
    logic [14:0] int_last_addr = '0;
    logic [18:0] fl_last_addr = '0;
    logic [3:0]  fl_last_be = '0;
    logic [31:0] fl_last_wd = '0;

    initial begin
        for (int i = 0; i < 256; i++) imem[i] = '0;
    end

    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            int_ready = 1'b0;
            if (int_req) begin
                cnt++;
                if (cnt >= int_lat) begin
                    cnt = 0;
                    int_ready = 1'b1;
                    int_txn++;
                    int_last_addr = int_addr;
                    if (int_we) begin
                        imem[int_addr[7:0]] = int_wdata;
                        int_wr_txn++;
                    end else begin
                        int_rdata = imem[int_addr[7:0]];
                    end
                end
            end
        end
    end

    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            fl_ready = 1'b0;
            if (fl_req) begin
                cnt++;
                if (cnt >= fl_lat) begin
                    cnt = 0;
                    fl_ready = 1'b1;
                    fl_txn++;
                    fl_last_addr = fl_addr;
                    if (fl_we) begin
                        fl_last_be = fl_be;
                        fl_last_wd = fl_wdata;
                    end else begin
                        fl_rdata = 32'hF000_0000 | {13'h0, fl_addr};
                    end
                end
            end
        end
    end

    // scoreboard
    logic [31:0] exp_q [$];
    string       tag_q [$];
    event        rd_done;
    int          last_busy = 0;

    initial begin
        forever begin
            logic [31:0] e;
            string       t;
            @(rd_done);
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(h_rdata === e, t, h_rdata, e);
        end
    end

    task automatic do_wr(input logic [4:0] ofs, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        h_addr = ofs; h_be = be; h_wdata = d; h_wr = 1'b1;
        @(posedge clk); #1;
        h_wr = 1'b0;
        while (!h_ready) begin @(posedge clk); #1; end
    endtask

    task automatic do_rd(input logic [4:0] ofs, input logic [3:0] be, input logic [31:0] exp, input string tag);
        int busy = 0;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        h_addr = ofs; h_be = be; h_rd = 1'b1;
        @(posedge clk); #1;
        h_rd = 1'b0;
        while (!h_ready) begin busy++; @(posedge clk); #1; end
        last_busy = busy;
        ->rd_done;
        #1;
    endtask

    task automatic set_ptr(input logic [31:0] p);
        do_wr(5'h00, 4'hF, p);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int snap_i, snap_f;
        repeat (3) @(posedge clk);
        #1;
        check(h_ready === 1'b1 && int_req === 1'b0 && fl_req === 1'b0, "R4 reset idle",
              {29'h0, h_ready, int_req, fl_req}, 32'h4);
        @(negedge clk); rst_pwr = 1'b0; rst_bus = 1'b0;
        do_rd(5'h00, 4'hF, 32'h0, "R4 pointer zero after reset");

        // pointer storage
        set_ptr(32'hFFFF_FFFF);
        do_rd(5'h00, 4'hF, 32'h000F_FFFF, "R3 upper bits read zero");
        do_wr(5'h00, 4'h3, 32'h0001_2345);
        do_rd(5'h00, 4'h1, 32'h000F_FFFF, "R2 narrow pointer write dropped / R5 full word");
        do_wr(5'h00, 4'hE, 32'h0000_0000);
        do_rd(5'h00, 4'h8, 32'h000F_FFFF, "R2 three-byte write dropped / R5");

        // undecoded offsets
        do_wr(5'h08, 4'hF, 32'h0000_AAAA);
        do_rd(5'h08, 4'hF, 32'h0, "R1 offset 0x08 reads zero");
        do_rd(5'h01, 4'hF, 32'h0, "R1 offset 0x01 reads zero");
        do_wr(5'h01, 4'hF, 32'h0000_0000);
        do_rd(5'h00, 4'hF, 32'h000F_FFFF, "R1 writes elsewhere leave pointer");

        // resets
        @(negedge clk); rst_bus = 1'b1; @(negedge clk); rst_bus = 1'b0;
        do_rd(5'h00, 4'hF, 32'h0, "R4 bus reset clears");
        set_ptr(32'h0000_1234);
        @(negedge clk); rst_pwr = 1'b1; @(negedge clk); rst_pwr = 1'b0;
        do_rd(5'h00, 4'hF, 32'h0, "R4 power reset clears");

        // internal range
        int_lat = 1;
        set_ptr(32'h0000_0104);
        do_wr(5'h04, 4'hF, 32'hDEAD_BEEF);
        check(int_wr_txn == 1, "R6 full write issued", int_wr_txn, 1);
        check(int_last_addr == 15'h41, "R6 word address", {17'h0, int_last_addr}, 32'h41);
        do_rd(5'h04, 4'h2, 32'hDEAD_BEEF, "R6 internal read back / R5");
        check(last_busy == 1, "R9 busy one cycle", last_busy, 1);
        snap_i = int_txn;
        do_wr(5'h04, 4'h1, 32'h1111_1111);
        check(int_txn == snap_i, "R6 narrow internal write not issued", int_txn, snap_i);
        do_rd(5'h04, 4'hF, 32'hDEAD_BEEF, "R6 data unchanged after narrow write");
        set_ptr(32'h0000_0107);
        do_rd(5'h04, 4'hF, 32'hDEAD_BEEF, "R6 low pointer bits ignored");
        int_lat = 3;
        do_rd(5'h04, 4'hF, 32'hDEAD_BEEF, "R9 slow internal read");
        check(last_busy == 3, "R9 ready low for latency", last_busy, 3);
        snap_i = int_txn;
        set_ptr(32'h0001_FFFC);
        do_rd(5'h04, 4'hF, 32'h0, "R6 top internal word");
        check(int_txn == snap_i + 1, "R6 0x1FFFC goes internal", int_txn, snap_i + 1);

        // flash range
        fl_lat = 2;
        snap_i = int_txn;
        set_ptr(32'h0008_0010);
        do_wr(5'h04, 4'h5, 32'h5555_AAAA);
        check(fl_last_addr == 19'h10, "R7 flash offset", {13'h0, fl_last_addr}, 32'h10);
        check(fl_last_be == 4'h5, "R7 flash byte enables", {28'h0, fl_last_be}, 32'h5);
        check(fl_last_wd == 32'h5555_AAAA, "R7 flash write data", fl_last_wd, 32'h5555_AAAA);
        do_rd(5'h04, 4'hF, 32'hF000_0010, "R7 flash read");
        check(last_busy == 2, "R9 flash latency", last_busy, 2);
        set_ptr(32'h000F_FFFF);
        do_rd(5'h04, 4'hF, 32'hF007_FFFF, "R7 last flash byte");
        check(int_txn == snap_i, "R10 no internal traffic on flash access", int_txn, snap_i);

        // undefined range and its edges
        snap_i = int_txn; snap_f = fl_txn;
        set_ptr(32'h0003_0000);
        do_wr(5'h04, 4'hF, 32'hCAFE_F00D);
        do_rd(5'h04, 4'hF, 32'h0, "R8 undefined read zero");
        set_ptr(32'h0002_0000);
        do_rd(5'h04, 4'hF, 32'h0, "R8 first undefined address");
        set_ptr(32'h0007_FFFF);
        do_rd(5'h04, 4'hF, 32'h0, "R8 last undefined address");
        check(int_txn == snap_i && fl_txn == snap_f, "R8 no port activity",
              int_txn + fl_txn, snap_i + snap_f);

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule